// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers of a 32-bit processor core and shows the datapath sixteen logical registers, numbered 0 to 15. Behind that view sit thirty physical general registers and one program counter. The 5-bit processor mode chooses which physical register a logical number reaches. The fast-interrupt mode keeps its own copies of registers 8 to 14. Four other exception modes each keep their own copies of registers 13 (stack pointer) and 14 (link register). User and System modes share the base set.

The block has two combinational read ports and one write port that updates on the clock edge. A separate fetch-advance input moves the program counter forward by one 32-bit instruction per fetch. The program counter is the fetch address, so in a three-stage fetch/decode/execute pipeline a read of register 15 by the executing instruction returns that instruction's address plus 8. Register 15 is common to every mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register in every bank reads 0, and `pc_out` and register 15 read 0.
- R2: Mode codes 5'b10000 (User) and 5'b11111 (System) reach the same physical registers for indices 0 to 14.
- R3: In mode 5'b10001 (fast interrupt), indices 8 to 14 reach registers private to that mode. Indices 0 to 7 are shared with User.
- R4: Modes 5'b10010, 5'b10011, 5'b10111 and 5'b11011 each reach their own private registers at indices 13 and 14. Indices 0 to 12 are shared with User.
- R5: Any mode code other than the seven listed in R2 to R4 reaches the User registers.
- R6: The two read ports return the selected register combinationally and independently of each other, in the current mode.
- R7: A write to indices 0 to 14 takes effect at the rising clock edge, into the bank of the current mode. A read of the same register in the write cycle returns the old value.
- R8: When `fetch_en` is high and register 15 is not being written, `pc_out` increases by 4 at the next edge.
- R9: A read of index 15 on either port returns the current `pc_out` in every mode. With one fetch per cycle, this equals the executing instruction's address plus 8.
- R10: A write to index 15 loads the program counter with bits [1:0] of the data forced to 0. It takes priority over `fetch_en` in that cycle.
- R11: When `fetch_en` is low and register 15 is not written, `pc_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| fetch_en | input | 1 | Advance the program counter by one instruction |
| pc_out | output | 32 | Current fetch address (program counter) |

## Verification
The write-then-read assertion depends on the mode being held across the two cycles it observes. It therefore compares only when the mode and index match the previous cycle. The bench holds the mode steady for each sweep of writes and reads. The program-counter assertions assume `fetch_en` and the write port are driven only between clock edges. The bench drives all inputs on the falling edge and samples just before the next rising edge. Mode sweeps cover the seven legal codes and a set of illegal codes.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fetch_en,
  output logic [DATA_W-1:0] pc_out
);
  localparam int NPHYS = 30;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [3:0] PC_IDX = 4'd15;

  logic [DATA_W-1:0] regs [NPHYS];
  logic [DATA_W-1:0] pc_q;

  // slots: 0-14 base, 15-21 fiq r8-r14, 22-29 r13/r14 of irq, svc, abt, und
  function automatic logic [4:0] slot_of(input logic [4:0] m, input logic [3:0] r);
    logic [4:0] rr;
    logic [4:0] s;
    rr = {1'b0, r};
    s  = rr;
    if (m == M_FIQ && r >= 4'd8)
      s = rr + 5'd7;
    else if (r >= 4'd13) begin
      case (m)
        M_IRQ:   s = rr + 5'd9;
        M_SVC:   s = rr + 5'd11;
        M_ABT:   s = rr + 5'd13;
        M_UND:   s = rr + 5'd15;
        default: s = rr;
      endcase
    end
    return s;
  endfunction

  wire pc_wr = wr_en && (wr_idx == PC_IDX);

  assign rd_a_data = (rd_a_idx == PC_IDX) ? pc_q : regs[slot_of(mode, rd_a_idx)];
  assign rd_b_data = (rd_b_idx == PC_IDX) ? pc_q : regs[slot_of(mode, rd_b_idx)];
  assign pc_out    = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else if (wr_en && !pc_wr) begin
      regs[slot_of(mode, wr_idx)] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (pc_wr)    pc_q <= {wr_data[DATA_W-1:2], 2'b00};
    else if (fetch_en) pc_q <= pc_q + DATA_W'(4);
  end
endmodule

module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              fetch_en,
  input logic [DATA_W-1:0] pc_out
);
  wire pc_wr = wr_en && (wr_idx == 4'd15);

  assert_fetch_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !pc_wr) |=> (pc_out == $past(pc_out) + DATA_W'(4)));

  assert_pc_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |=> (pc_out == {$past(wr_data[DATA_W-1:2]), 2'b00}));

  assert_pc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !pc_wr) |=> $stable(pc_out));

  assert_r15_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == pc_out));

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 4'd15) ##1 (rd_a_idx == $past(wr_idx) && mode == $past(mode))
      |-> (rd_a_data == $past(wr_data)));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .fetch_en(fetch_en), .pc_out(pc_out));

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  mode = 5'b10000;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, pc_out;
  logic        wr_en = 0, fetch_en = 0;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  banked_regfile dut_i (.*);

  logic [4:0] modes [12] = '{5'b10000, 5'b11111, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                             5'b11011, 5'b00000, 5'b10100, 5'b11110, 5'b01111, 5'b10110};
  logic [31:0] mdl [6][15];

  function automatic int bank_of(input logic [4:0] m, input int r);
    int b = 0;
    if (m == 5'b10001 && r >= 8) b = 1;
    else if (r >= 13) begin
      if (m == 5'b10010) b = 2;
      if (m == 5'b10011) b = 3;
      if (m == 5'b10111) b = 4;
      if (m == 5'b11011) b = 5;
    end
    return b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h (mode %b)", req, act, exp, mode);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic read_all(input string req);
    for (int mi = 0; mi < 12; mi++) begin
      mode = modes[mi];
      for (int r = 0; r < 15; r++) begin
        rd_a_idx = 4'(r); rd_b_idx = 4'(14 - r);
        #1;
        check(req, rd_a_data, mdl[bank_of(mode, r)][r]);
        check("R6", rd_b_data, mdl[bank_of(mode, 14 - r)][14 - r]);
      end
    end
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 6; b++) for (int r = 0; r < 15; r++) mdl[b][r] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1; #1;
    // R1: reset state
    check("R1", pc_out, 32'h0);
    read_all("R1");
    // R2/R3/R4/R5: write every index in each legal mode, then read back in all modes
    for (int mi = 0; mi < 7; mi++) begin
      mode = modes[mi];
      for (int r = 0; r < 15; r++) begin
        wr_en = 1; wr_idx = 4'(r); wr_data = 32'hC000_0000 | (mi << 12) | (r << 4) | 32'h5;
        rd_a_idx = 4'(r); #1;
        check("R7", rd_a_data, mdl[bank_of(mode, r)][r]);
        tick;
        mdl[bank_of(mode, r)][r] = wr_data;
        wr_en = 0; #1;
        check("R7", rd_a_data, wr_data);
      end
      read_all(mi < 2 ? "R2" : (mi == 2 ? "R3" : "R4"));
    end
    read_all("R5");
    // R8: fetch advance; R9: R15 read
    mode = 5'b10011; rd_a_idx = 15; rd_b_idx = 15;
    fetch_en = 1;
    for (int k = 1; k <= 20; k++) begin
      tick;
      check("R8", pc_out, 32'(4 * k));
      check("R9", rd_a_data, 32'(4 * k));
      check("R9", rd_b_data, 32'(4 * k));
      // executing instruction was fetched two cycles ago
      if (k >= 2) check("R9", rd_a_data - 32'd8, 32'(4 * (k - 2)));
    end
    // R11: hold
    fetch_en = 0;
    for (int k = 0; k < 5; k++) begin tick; check("R11", pc_out, 32'd80); end
    // R10: PC write, low bits cleared, priority over fetch
    for (int v = 0; v < 4; v++) begin
      fetch_en = v[0]; wr_en = 1; wr_idx = 15; wr_data = 32'h1234_5670 | 32'(v) | (v << 20);
      tick;
      wr_en = 0; fetch_en = 0;
      check("R10", pc_out, wr_data & 32'hFFFF_FFFC);
      for (int mi = 0; mi < 12; mi++) begin
        mode = modes[mi]; #1;
        check("R9", rd_a_data, wr_data & 32'hFFFF_FFFC);
      end
    end
    // R10: the register file is not touched by an R15 write
    read_all("R10");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule